// File: doc/BRIEF.md
# Pause Frame Receive Decoder

This block sits beside the receive path of an Ethernet MAC. It inspects the received frame one byte per beat and picks out MAC control pause frames. When it finds one, it holds off the local transmitter for the number of slot times carried in the frame. One slot time is 512 bit times, and a one-cycle tick input marks each elapsed slot.

The byte stream enters on a valid/ready interface. `rx_ready` is held high at all times, so the block never applies back-pressure. A byte moves only on a cycle where `rx_valid` is high. The upstream receiver supplies the start and end markers. It also gives the FCS verdict, which is valid on the end beat.

The address filter always accepts the reserved pause multicast address 01-80-C2-00-00-01. A control input can widen it to also accept the station's own unicast address. Decoding works only when receive flow control is enabled and the link is in full duplex. The remaining pause time is visible as a counter.

Top module: `pause_rx_decoder`

## Requirements
- R1: After reset, `pause_count` is 0 and `tx_pause` is 0.
- R2: A qualifying frame loads `pause_count` with the 16-bit quanta in byte offsets 16 (high byte) and 17 (low byte). Offset 0 is the first byte of the destination address. The load is seen two clock edges after the end beat is accepted. `tx_pause` is high exactly while `pause_count` is non-zero.
- R3: Each cycle with `slot_tick` high lowers a non-zero `pause_count` by one. At 0, the count stays at 0.
- R4: With `ucast_en` low, the only destination accepted is 01-80-C2-00-00-01, sent in byte offsets 0..5, most significant byte first. With `ucast_en` high, a destination equal to `station_addr` (bits 47:40 at offset 0) is also accepted. Any other destination is ignored.
- R5: A frame is ignored unless offsets 12..13 hold type 0x8808 and offsets 14..15 hold opcode 0x0001.
- R6: A frame whose `rx_fcs_ok` is low on its end beat is ignored, and `pause_count` keeps its value.
- R7: While `rx_flow_en` is low, `pause_count` is forced to 0 on the next edge and no frame is decoded.
- R8: While `full_duplex` is low, `pause_count` is forced to 0 on the next edge and no frame is decoded.
- R9: A qualifying frame reloads the counter even while a pause runs. A quanta of 0 ends the pause at once. A load takes priority over a slot tick in the same cycle.
- R10: `pause_count` never changes because of a frame before that frame's end beat. A frame whose end beat comes before offset 17 is ignored.
- R11: `rx_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte is valid this cycle |
| rx_ready | output | 1 | Always 1; no back-pressure |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_fcs_ok | input | 1 | FCS verdict, valid on the end beat |
| rx_flow_en | input | 1 | Receive flow control enable |
| ucast_en | input | 1 | Also accept the station unicast address |
| station_addr | input | 48 | Station MAC address |
| full_duplex | input | 1 | Link is in full-duplex mode |
| slot_tick | input | 1 | One-cycle pulse per elapsed slot time |
| tx_pause | output | 1 | Hold off the transmitter |
| pause_count | output | 16 | Remaining pause time in slots |

## Verification
The bench sends frames that differ in one field at a time:
- a destination one bit away from the station address;
- a near-miss type or opcode;
- a bad FCS;
- a frame that ends one byte before the quanta is complete.

A decoder that skips any of these checks would pause on a frame it should drop. The bench then checks the counter on the cycle before the end beat, where a design that loads early would show the new value too soon.

It also covers:
- a reload over a running pause;
- a zero quanta, which must clear the pause;
- a tick in the same cycle as a load, where the load must win;
- a tick at zero, which must not wrap.

Finally, it drops flow enable and duplex in the middle of a pause. A design that only gates new frames would leave the transmitter held off.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 48;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int QUANTA_W  = 16;
  localparam int POS_W     = 5;
  localparam int TYPE_POS  = 12;
  localparam int OPC_POS   = 14;
  localparam int QNT_POS   = 16;
  localparam int LAST_POS  = QNT_POS + 1;
  localparam int MIN_LEN   = LAST_POS + 1;
  localparam logic [ADDR_W-1:0]   PAUSE_MCAST = 48'h0180_C200_0001;
  localparam logic [QUANTA_W-1:0] CTL_ETYPE   = 16'h8808;
  localparam logic [QUANTA_W-1:0] PAUSE_OPC   = 16'h0001;
endpackage

// File: rtl/pfd_addr_cmp.sv
module pfd_addr_cmp
  import pfd_pkg::*;
(
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] data,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              mc_byte_ok,
  output logic              uc_byte_ok
);
  logic [ADDR_BYTES-1:0] mc_sel;
  logic [ADDR_BYTES-1:0] uc_sel;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign mc_sel[b] = (data == PAUSE_MCAST[ADDR_W-1-BYTE_W*b -: BYTE_W]);
    assign uc_sel[b] = (data == station_addr[ADDR_W-1-BYTE_W*b -: BYTE_W]);
  end

  always_comb begin
    mc_byte_ok = 1'b1;
    uc_byte_ok = 1'b1;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (pos == POS_W'(b)) begin
        mc_byte_ok = mc_sel[b];
        uc_byte_ok = uc_sel[b];
      end
    end
  end
endmodule

// File: rtl/pfd_frame_parser.sv
module pfd_frame_parser
  import pfd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic                rx_fcs_ok,
  input  logic                ucast_en,
  input  logic [ADDR_W-1:0]   station_addr,
  output logic                accept,
  output logic [QUANTA_W-1:0] quanta
);
  logic [POS_W-1:0]    pos_q;
  logic                in_frame_q;
  logic                mc_q, uc_q, type_q, opc_q;
  logic [BYTE_W-1:0]   qhi_q;
  logic [POS_W-1:0]    cur_pos;
  logic                beat;
  logic                mc_b, uc_b;
  logic                mc_n, uc_n, type_n, opc_n;
  logic                len_ok;

  assign cur_pos = rx_sof ? '0 : pos_q;
  assign beat    = rx_valid && (rx_sof || in_frame_q);

  pfd_addr_cmp u_addr (
    .pos          (cur_pos),
    .data         (rx_data),
    .station_addr (station_addr),
    .mc_byte_ok   (mc_b),
    .uc_byte_ok   (uc_b)
  );

  always_comb begin
    mc_n   = (rx_sof ? 1'b1 : mc_q) && mc_b;
    uc_n   = (rx_sof ? 1'b1 : uc_q) && uc_b;
    type_n = rx_sof ? 1'b1 : type_q;
    opc_n  = rx_sof ? 1'b1 : opc_q;
    if (cur_pos == POS_W'(TYPE_POS))     type_n = type_n && (rx_data == CTL_ETYPE[15:8]);
    if (cur_pos == POS_W'(TYPE_POS + 1)) type_n = type_n && (rx_data == CTL_ETYPE[7:0]);
    if (cur_pos == POS_W'(OPC_POS))      opc_n  = opc_n  && (rx_data == PAUSE_OPC[15:8]);
    if (cur_pos == POS_W'(OPC_POS + 1))  opc_n  = opc_n  && (rx_data == PAUSE_OPC[7:0]);
  end

  assign len_ok = (cur_pos >= POS_W'(LAST_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
      mc_q       <= 1'b0;
      uc_q       <= 1'b0;
      type_q     <= 1'b0;
      opc_q      <= 1'b0;
      qhi_q      <= '0;
      accept     <= 1'b0;
      quanta     <= '0;
    end else begin
      accept <= 1'b0;
      if (beat) begin
        mc_q   <= mc_n;
        uc_q   <= uc_n;
        type_q <= type_n;
        opc_q  <= opc_n;
        if (cur_pos == POS_W'(QNT_POS)) qhi_q <= rx_data;
        if (cur_pos < POS_W'(MIN_LEN)) pos_q <= cur_pos + 1'b1;
        else                           pos_q <= cur_pos;
        in_frame_q <= !rx_eof;
        if (rx_eof) begin
          accept <= len_ok && type_n && opc_n && rx_fcs_ok && (mc_n || (ucast_en && uc_n));
          quanta <= {qhi_q, rx_data};
          if (cur_pos > POS_W'(LAST_POS)) quanta <= {qhi_q, quanta[7:0]};
        end else if (cur_pos == POS_W'(LAST_POS)) begin
          quanta <= {qhi_q, rx_data};
        end
      end
    end
  end
endmodule

// File: rtl/pfd_pause_timer.sv
module pfd_pause_timer
  import pfd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                tick,
  output logic [QUANTA_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       count <= '0;
    else if (!enable)                 count <= '0;
    else if (load)                    count <= load_val;
    else if (tick && (count != '0))   count <= count - 1'b1;
  end
endmodule

// File: rtl/pause_rx_decoder.sv
module pause_rx_decoder
  import pfd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  output logic                rx_ready,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic                rx_fcs_ok,
  input  logic                rx_flow_en,
  input  logic                ucast_en,
  input  logic [ADDR_W-1:0]   station_addr,
  input  logic                full_duplex,
  input  logic                slot_tick,
  output logic                tx_pause,
  output logic [QUANTA_W-1:0] pause_count
);
  logic                frame_accept;
  logic [QUANTA_W-1:0] accept_quanta;
  logic                decode_en;

  assign rx_ready  = 1'b1;
  assign decode_en = rx_flow_en && full_duplex;

  pfd_frame_parser u_parser (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid && decode_en),
    .rx_data      (rx_data),
    .rx_sof       (rx_sof),
    .rx_eof       (rx_eof),
    .rx_fcs_ok    (rx_fcs_ok),
    .ucast_en     (ucast_en),
    .station_addr (station_addr),
    .accept       (frame_accept),
    .quanta       (accept_quanta)
  );

  pfd_pause_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (decode_en),
    .load     (frame_accept),
    .load_val (accept_quanta),
    .tick     (slot_tick),
    .count    (pause_count)
  );

  assign tx_pause = (pause_count != '0);
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker
  import pfd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rx_ready,
  input logic                rx_flow_en,
  input logic                full_duplex,
  input logic                slot_tick,
  input logic                frame_accept,
  input logic [QUANTA_W-1:0] accept_quanta,
  input logic                tx_pause,
  input logic [QUANTA_W-1:0] pause_count
);
  a_r11_always_ready: assert property (@(posedge clk) disable iff (!rst_n) rx_ready);

  a_r7_flow_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flow_en |=> (pause_count == '0) && !tx_pause);

  a_r8_half_duplex_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !full_duplex |=> (pause_count == '0) && !tx_pause);

  a_r3_tick_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_en && full_duplex && !frame_accept && slot_tick && pause_count != '0)
      |=> pause_count == $past(pause_count) - 1'b1);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flow_en && full_duplex && frame_accept) |=> pause_count == $past(accept_quanta));

  a_r10_no_rise_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_accept |=> pause_count <= $past(pause_count));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pause_count == '0));
endmodule

bind pause_rx_decoder pfd_checker u_pfd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_ready      (rx_ready),
  .rx_flow_en    (rx_flow_en),
  .full_duplex   (full_duplex),
  .slot_tick     (slot_tick),
  .frame_accept  (frame_accept),
  .accept_quanta (accept_quanta),
  .tx_pause      (tx_pause),
  .pause_count   (pause_count)
);

// File: tb/pause_rx_decoder_bench.sv
module pause_rx_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic        rx_fcs_ok = 1'b0;
  logic        rx_flow_en = 1'b1;
  logic        ucast_en = 1'b0;
  logic [47:0] station_addr = 48'h0211_2233_4455;
  logic        full_duplex = 1'b1;
  logic        slot_tick = 1'b0;
  logic        tx_pause;
  logic [15:0] pause_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [47:0] MC  = 48'h0180_C200_0001;
  localparam logic [47:0] STA = 48'h0211_2233_4455;
  localparam logic [47:0] SRC = 48'h00AA_BBCC_DDEE;

  typedef struct packed {
    logic [47:0] dst;
    logic [15:0] typ;
    logic [15:0] opc;
    logic [15:0] qnt;
    logic        fcs;
    logic        uc;
    logic [7:0]  len;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{MC,  16'h8808, 16'h0001, 16'h0100, 1'b1, 1'b0, 8'd60, 16'h0100},
    '{STA, 16'h8808, 16'h0001, 16'h0044, 1'b1, 1'b0, 8'd60, 16'h0000},
    '{STA, 16'h8808, 16'h0001, 16'h0033, 1'b1, 1'b1, 8'd60, 16'h0033},
    '{48'h0211_2233_4454, 16'h8808, 16'h0001, 16'h0022, 1'b1, 1'b1, 8'd60, 16'h0000},
    '{MC,  16'h8800, 16'h0001, 16'h0011, 1'b1, 1'b0, 8'd60, 16'h0000},
    '{MC,  16'h8808, 16'h0002, 16'h0011, 1'b1, 1'b0, 8'd60, 16'h0000},
    '{MC,  16'h8808, 16'h0001, 16'h0011, 1'b0, 1'b0, 8'd60, 16'h0000},
    '{MC,  16'h8808, 16'h0001, 16'h0011, 1'b1, 1'b0, 8'd17, 16'h0000},
    '{MC,  16'h8808, 16'h0001, 16'h0007, 1'b1, 1'b0, 8'd18, 16'h0007},
    '{MC,  16'h8808, 16'h0001, 16'hFFFF, 1'b1, 1'b1, 8'd64, 16'hFFFF}
  };

  localparam string VTAG [NV] = '{"R2", "R4", "R4", "R4", "R5", "R5", "R6", "R10", "R10", "R2"};

  pause_rx_decoder u_pause_rx_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
    .rx_flow_en(rx_flow_en), .ucast_en(ucast_en), .station_addr(station_addr),
    .full_duplex(full_duplex), .slot_tick(slot_tick), .tx_pause(tx_pause),
    .pause_count(pause_count)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [47:0] dst, input logic [15:0] typ,
                                       input logic [15:0] opc, input logic [15:0] q, input int i);
    if (i < 6)       return dst[47-8*i -: 8];
    else if (i < 12) return SRC[47-8*(i-6) -: 8];
    else if (i == 12) return typ[15:8];
    else if (i == 13) return typ[7:0];
    else if (i == 14) return opc[15:8];
    else if (i == 15) return opc[7:0];
    else if (i == 16) return q[15:8];
    else if (i == 17) return q[7:0];
    else             return 8'h00;
  endfunction

  task automatic send(input logic [47:0] dst, input logic [15:0] typ, input logic [15:0] opc,
                      input logic [15:0] q, input bit fcs, input int len,
                      input bit mid, input logic [15:0] mid_exp);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (mid && i == len - 1) chk("R10 count before end beat", pause_count, mid_exp);
      rx_valid  = 1'b1;
      rx_data   = fbyte(dst, typ, opc, q, i);
      rx_sof    = (i == 0);
      rx_eof    = (i == len - 1);
      rx_fcs_ok = (i == len - 1) ? fcs : 1'b0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_fcs_ok = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_pause();
    @(negedge clk); rx_flow_en = 1'b0;
    @(negedge clk); rx_flow_en = 1'b1;
  endtask

  task automatic tick();
    @(negedge clk); slot_tick = 1'b1;
    @(negedge clk); slot_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset count", pause_count, 0);
    chk("R1 reset pause", tx_pause, 0);
    chk("R11 ready", rx_ready, 1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      clear_pause();
      ucast_en = VEC[v].uc;
      send(VEC[v].dst, VEC[v].typ, VEC[v].opc, VEC[v].qnt, VEC[v].fcs, int'(VEC[v].len), 1'b0, 16'h0);
      chk(VTAG[v], pause_count, VEC[v].exp_cnt);
      chk(VTAG[v], tx_pause, VEC[v].exp_cnt != 0);
    end
    ucast_en = 1'b0;

    // R3 tick down and floor at zero
    clear_pause();
    send(MC, 16'h8808, 16'h0001, 16'h0003, 1'b1, 60, 1'b0, 16'h0);
    tick(); chk("R3 tick 1", pause_count, 2);
    tick(); chk("R3 tick 2", pause_count, 1);
    tick(); chk("R3 tick 3", pause_count, 0);
    chk("R3 pause ends", tx_pause, 0);
    tick(); chk("R3 no wrap", pause_count, 0);

    // R9 and R10: reload while running, counter held until end beat
    send(MC, 16'h8808, 16'h0001, 16'h0050, 1'b1, 60, 1'b0, 16'h0);
    send(MC, 16'h8808, 16'h0001, 16'h0010, 1'b1, 60, 1'b1, 16'h0050);
    chk("R9 reload", pause_count, 16'h0010);
    send(MC, 16'h8808, 16'h0001, 16'h0000, 1'b1, 60, 1'b0, 16'h0);
    chk("R9 zero quanta", pause_count, 0);
    chk("R9 zero ends pause", tx_pause, 0);

    // R6 bad FCS keeps running count
    send(MC, 16'h8808, 16'h0001, 16'h0020, 1'b1, 60, 1'b0, 16'h0);
    send(MC, 16'h8808, 16'h0001, 16'h0090, 1'b0, 60, 1'b0, 16'h0);
    chk("R6 count kept", pause_count, 16'h0020);

    // R9 load beats tick in the same cycle
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fbyte(MC, 16'h8808, 16'h0001, 16'h0040, i);
      rx_sof = (i == 0); rx_eof = (i == 59); rx_fcs_ok = (i == 59);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; rx_fcs_ok = 1'b0; slot_tick = 1'b1;
    @(negedge clk); slot_tick = 1'b0;
    chk("R9 load over tick", pause_count, 16'h0040);

    // R7 flow disable clears and blocks
    @(negedge clk); rx_flow_en = 1'b0;
    @(negedge clk);
    chk("R7 cleared", pause_count, 0);
    send(MC, 16'h8808, 16'h0001, 16'h0030, 1'b1, 60, 1'b0, 16'h0);
    chk("R7 no decode", pause_count, 0);
    chk("R7 no pause", tx_pause, 0);
    rx_flow_en = 1'b1;

    // R8 half duplex clears and blocks
    send(MC, 16'h8808, 16'h0001, 16'h0030, 1'b1, 60, 1'b0, 16'h0);
    chk("R8 setup", pause_count, 16'h0030);
    @(negedge clk); full_duplex = 1'b0;
    @(negedge clk);
    chk("R8 cleared", pause_count, 0);
    send(MC, 16'h8808, 16'h0001, 16'h0030, 1'b1, 60, 1'b0, 16'h0);
    chk("R8 no decode", tx_pause, 0);
    full_duplex = 1'b1;
    chk("R11 ready after traffic", rx_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule